// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits on the host write path of a NOR-flash style device. It watches each write cycle, which carries a word address, a 16-bit data word and a write strobe, and follows the command sequences the host issues. A normal command opens with two unlock writes. If the third write is the bypass-entry code, the decoder switches into a persistent fast-program mode. In that mode every program needs only two writes: a setup code and then the data word at its target address.

When a program sequence completes, the decoder raises a single-cycle request that carries the captured address and data for the embedded program logic. It also reports whether fast-program mode is active. The mode ends only through a dedicated two-write exit sequence. A busy input from the embedded-algorithm logic makes the decoder ignore host writes completely.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While reset is asserted and after it is released, with no write seen, `bypass_active` and `prog_req` are 0 and `prog_addr` and `prog_data` are all zeros.
- R2: From idle, the writes 0x00AA at offset 0x555, then 0x0055 at offset 0x2AA, then 0x0020 at offset 0x555 set `bypass_active` to 1 in the cycle after the third write.
- R3: Offset comparison against 0x555 and 0x2AA uses only the low 12 word-address bits, and higher address bits have no effect.
- R4: In bypass mode, a write of 0x00A0 at any address followed by a write of any data at any address gives `prog_req` = 1 for exactly the one cycle after the data write. In that cycle `prog_addr` and `prog_data` equal the address and data of that data write.
- R5: After a bypass program, further words are programmed by repeating only the two-write sequence, and `bypass_active` stays 1 throughout.
- R6: In bypass mode, a write of 0x0090 followed by a write of 0x0000, both at any address, clears `bypass_active` in the cycle after the second write. Afterwards a setup/data pair produces no request.
- R7: Outside bypass mode, a write that does not match the next expected unlock or entry cycle returns the decoder to idle, so no bypass is entered without a fresh complete sequence.
- R8: In bypass mode, a write that does not match the next expected cycle returns the decoder to bypass-idle. `bypass_active` stays 1 and no request is issued.
- R9: A write presented while `busy` is 1 is ignored: the sequence state does not change and no request results from it.
- R10: `prog_addr` and `prog_data` hold their values until the next request.
- R11: The write after a bypass setup is always taken as program data, even when its value equals the setup or exit code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Host word address of the write |
| wr_data | input | 16 | Host write data |
| busy | input | 1 | Embedded algorithm running; writes are ignored while high |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Captured program address |
| prog_data | output | 16 | Captured program data |
| bypass_active | output | 1 | Fast-program (bypass) mode is active |

## Verification
The embedded assertions check on every cycle the properties that do not depend on history. A request lasts one cycle and appears only in bypass mode, directly after an accepted write. The sequence state is frozen while busy is high or no write is presented. The captured address and data stay put between requests. Bypass turns on only after an entry-code write and off only after a zero write. The directed scenarios are needed for the behaviour that depends on ordering: full sequences, the restart after a mismatch in each mode, the masking of upper address bits, the data write that happens to carry a command code, and a busy write placed between two unlock cycles.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE      = 3'd0,
    SEQ_KEY1_SEEN = 3'd1,
    SEQ_KEY2_SEEN = 3'd2,
    SEQ_FAST_IDLE = 3'd3,
    SEQ_FAST_ARM  = 3'd4,
    SEQ_FAST_QUIT = 3'd5
  } seq_state_t;

  localparam logic [15:0] CODE_KEY1      = 16'h00AA;
  localparam logic [15:0] CODE_KEY2      = 16'h0055;
  localparam logic [15:0] CODE_FAST_ON   = 16'h0020;
  localparam logic [15:0] CODE_FAST_PROG = 16'h00A0;
  localparam logic [15:0] CODE_QUIT1     = 16'h0090;
  localparam logic [15:0] CODE_QUIT2     = 16'h0000;

  localparam logic [11:0] OFS_KEY1 = 12'h555;
  localparam logic [11:0] OFS_KEY2 = 12'h2AA;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
#(
  parameter int MATCH_W = 12
) (
  input  logic [MATCH_W-1:0] addr_low,
  input  logic [15:0]        data,
  output logic               hit_key1,
  output logic               hit_key2,
  output logic               hit_fast_on,
  output logic               hit_fast_prog,
  output logic               hit_quit1,
  output logic               hit_quit2
);

  localparam logic [MATCH_W-1:0] OFS_A = MATCH_W'(OFS_KEY1);
  localparam logic [MATCH_W-1:0] OFS_B = MATCH_W'(OFS_KEY2);

  logic at_ofs_a;
  logic at_ofs_b;

  always_comb begin
    at_ofs_a      = (addr_low == OFS_A);
    at_ofs_b      = (addr_low == OFS_B);
    hit_key1      = at_ofs_a && (data == CODE_KEY1);
    hit_key2      = at_ofs_b && (data == CODE_KEY2);
    hit_fast_on   = at_ofs_a && (data == CODE_FAST_ON);
    hit_fast_prog = (data == CODE_FAST_PROG);
    hit_quit1     = (data == CODE_QUIT1);
    hit_quit2     = (data == CODE_QUIT2);
  end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic busy,
  input  logic hit_key1,
  input  logic hit_key2,
  input  logic hit_fast_on,
  input  logic hit_fast_prog,
  input  logic hit_quit1,
  input  logic hit_quit2,
  output logic issue,
  output logic fast_mode
);

  seq_state_t state_q;
  seq_state_t state_d;
  logic       take;

  assign take = wr_en && !busy;

  always_comb begin
    state_d = state_q;
    issue   = 1'b0;
    unique case (state_q)
      SEQ_IDLE:      state_d = hit_key1 ? SEQ_KEY1_SEEN : SEQ_IDLE;
      SEQ_KEY1_SEEN: state_d = hit_key2 ? SEQ_KEY2_SEEN : SEQ_IDLE;
      SEQ_KEY2_SEEN: state_d = hit_fast_on ? SEQ_FAST_IDLE : SEQ_IDLE;
      SEQ_FAST_IDLE: begin
        if (hit_fast_prog)  state_d = SEQ_FAST_ARM;
        else if (hit_quit1) state_d = SEQ_FAST_QUIT;
        else                state_d = SEQ_FAST_IDLE;
      end
      SEQ_FAST_ARM: begin
        state_d = SEQ_FAST_IDLE;
        issue   = take;
      end
      SEQ_FAST_QUIT: state_d = hit_quit2 ? SEQ_IDLE : SEQ_FAST_IDLE;
      default:       state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= SEQ_IDLE;
    else if (take) state_q <= state_d;
  end

  assign fast_mode = (state_q == SEQ_FAST_IDLE) || (state_q == SEQ_FAST_ARM) ||
                     (state_q == SEQ_FAST_QUIT);

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(state_q)); // R9

  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(state_q)); // R9

  AST_ENTRY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_mode) |-> $past(hit_fast_on) && $past(take)); // R2

  AST_EXIT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fast_mode) |-> $past(hit_quit2) && $past(take)); // R6

endmodule

// File: rtl/flash_cmd_req.sv
module flash_cmd_req #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [15:0]       prog_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prog_req <= 1'b0;
    else        prog_req <= issue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_addr <= '0;
      prog_data <= '0;
    end else if (issue) begin
      prog_addr <= wr_addr;
      prog_data <= wr_data;
    end
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req); // R4

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_req |-> $stable(prog_addr) && $stable(prog_data)); // R10

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W  = 20,
  parameter int MATCH_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              busy,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [15:0]       prog_data,
  output logic              bypass_active
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       hit_key1, hit_key2, hit_fast_on, hit_fast_prog, hit_quit1, hit_quit2;
  logic       issue;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  flash_cmd_match #(.MATCH_W(MATCH_W)) u_match (
    .addr_low      (wr_addr[MATCH_W-1:0]),
    .data          (wr_data),
    .hit_key1      (hit_key1),
    .hit_key2      (hit_key2),
    .hit_fast_on   (hit_fast_on),
    .hit_fast_prog (hit_fast_prog),
    .hit_quit1     (hit_quit1),
    .hit_quit2     (hit_quit2)
  );

  flash_cmd_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .wr_en         (wr_en),
    .busy          (busy),
    .hit_key1      (hit_key1),
    .hit_key2      (hit_key2),
    .hit_fast_on   (hit_fast_on),
    .hit_fast_prog (hit_fast_prog),
    .hit_quit1     (hit_quit1),
    .hit_quit2     (hit_quit2),
    .issue         (issue),
    .fast_mode     (bypass_active)
  );

  flash_cmd_req #(.ADDR_W(ADDR_W)) u_req (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .issue     (issue),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .prog_req  (prog_req),
    .prog_addr (prog_addr),
    .prog_data (prog_data)
  );

  AST_REQ_IN_FAST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    prog_req |-> bypass_active); // R4

  AST_REQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    prog_req |-> $past(wr_en) && !$past(busy)); // R9

endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;

  localparam int ADDR_W = 20;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [15:0]       wr_data;
  logic              busy;
  logic              prog_req;
  logic [ADDR_W-1:0] prog_addr;
  logic [15:0]       prog_data;
  logic              bypass_active;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(ADDR_W), .MATCH_W(12)) u_flash_cmd_decoder (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .busy          (busy),
    .prog_req      (prog_req),
    .prog_addr     (prog_addr),
    .prog_data     (prog_data),
    .bypass_active (bypass_active)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic apply_reset();
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; busy = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // One write; returns at the negedge after the sampling edge.
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d, input logic b = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; busy = b;
    @(negedge clk);
    wr_en = 1'b0; busy = 1'b0;
  endtask

  task automatic enter_fast();
    wr(20'h00555, 16'h00AA);
    wr(20'h002AA, 16'h0055);
    wr(20'h00555, 16'h0020);
  endtask

  task automatic t_reset();
    wr_en = 1'b0; busy = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 bypass in reset", bypass_active, 0);
    check("R1 req in reset", prog_req, 0);
    apply_reset();
    check("R1 bypass after reset", bypass_active, 0);
    check("R1 addr after reset", prog_addr, 0);
    check("R1 data after reset", prog_data, 0);
  endtask

  task automatic t_entry();
    apply_reset();
    wr(20'h00555, 16'h00AA);
    wr(20'h002AA, 16'h0055);
    check("R2 not yet bypass", bypass_active, 0);
    wr(20'h00555, 16'h0020);
    check("R2 bypass entered", bypass_active, 1);
  endtask

  task automatic t_high_bits();
    apply_reset();
    wr(20'hFA555, 16'h00AA);
    wr(20'h3B2AA, 16'h0055);
    wr(20'h81555, 16'h0020);
    check("R3 upper bits ignored", bypass_active, 1);
  endtask

  task automatic t_program();
    apply_reset();
    enter_fast();
    wr(20'h12345, 16'h00A0);
    check("R4 no req on setup", prog_req, 0);
    wr(20'hABCDE, 16'hBEEF);
    check("R4 req pulse", prog_req, 1);
    check("R4 req addr", prog_addr, 20'hABCDE);
    check("R4 req data", prog_data, 16'hBEEF);
    @(negedge clk);
    check("R4 req one cycle", prog_req, 0);
    wr(20'h00010, 16'h00A0);
    wr(20'h00020, 16'h1111);
    check("R5 second req", prog_req, 1);
    check("R5 second data", prog_data, 16'h1111);
    check("R5 still bypass", bypass_active, 1);
    repeat (5) @(negedge clk);
    check("R10 addr held", prog_addr, 20'h00020);
    check("R10 data held", prog_data, 16'h1111);
  endtask

  task automatic t_code_as_data();
    apply_reset();
    enter_fast();
    wr(20'h00000, 16'h00A0);
    wr(20'h00042, 16'h0090);
    check("R11 0x90 programmed", prog_req, 1);
    check("R11 data 0x90", prog_data, 16'h0090);
    wr(20'h00000, 16'h0000);
    check("R11 no exit after data", bypass_active, 1);
    wr(20'h00000, 16'h00A0);
    wr(20'h00043, 16'h00A0);
    check("R11 0xA0 programmed", prog_req, 1);
  endtask

  task automatic t_exit();
    apply_reset();
    enter_fast();
    wr(20'h77777, 16'h0090);
    check("R6 still bypass after 1st", bypass_active, 1);
    wr(20'h01234, 16'h0000);
    check("R6 bypass left", bypass_active, 0);
    wr(20'h00000, 16'h00A0);
    wr(20'h00100, 16'h5555);
    check("R6 no req after exit", prog_req, 0);
    check("R6 addr unchanged", prog_addr, 0);
  endtask

  task automatic t_mismatch_normal();
    apply_reset();
    wr(20'h00555, 16'h00AA);
    wr(20'h002AB, 16'h0055);
    wr(20'h00555, 16'h0020);
    check("R7 bad 2nd addr", bypass_active, 0);
    wr(20'h00555, 16'h00AA);
    wr(20'h002AA, 16'h0055);
    wr(20'h00555, 16'h0021);
    wr(20'h00555, 16'h0020);
    check("R7 bad 3rd data", bypass_active, 0);
  endtask

  task automatic t_mismatch_fast();
    apply_reset();
    enter_fast();
    wr(20'h00000, 16'h0090);
    wr(20'h00000, 16'h1234);
    check("R8 bypass kept", bypass_active, 1);
    wr(20'h00000, 16'h0000);
    check("R8 lone zero no exit", bypass_active, 1);
    check("R8 no req", prog_req, 0);
  endtask

  task automatic t_busy();
    apply_reset();
    wr(20'h00555, 16'h00AA);
    wr(20'h00000, 16'h9999, 1'b1);
    wr(20'h002AA, 16'h0055);
    wr(20'h00555, 16'h0020);
    check("R9 busy write ignored in unlock", bypass_active, 1);
    wr(20'h00000, 16'h00A0, 1'b1);
    wr(20'h00050, 16'h1234);
    check("R9 setup under busy ignored", prog_req, 0);
    wr(20'h00000, 16'h00A0);
    wr(20'h00060, 16'h4321, 1'b1);
    check("R9 data under busy no req", prog_req, 0);
    wr(20'h00061, 16'h6789);
    check("R9 armed state kept", prog_req, 1);
    check("R9 armed data", prog_data, 16'h6789);
    wr(20'h00000, 16'h0090, 1'b1);
    wr(20'h00000, 16'h0000, 1'b1);
    check("R9 exit under busy ignored", bypass_active, 1);
  endtask

  initial begin
    t_reset();
    t_entry();
    t_high_bits();
    t_program();
    t_code_as_data();
    t_exit();
    t_mismatch_normal();
    t_mismatch_fast();
    t_busy();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule